// File: doc/BRIEF.md
# Debounced Octal Input Serializer

This block takes eight raw digital inputs, brings each one into the system clock domain through a two-flop synchronizer, and filters it with its own debounce counter. The debounce time is picked by two strap pins from three settings: none, one millisecond or three milliseconds. The filtered states feed an eight-bit parallel-load shift register that a host reads over an SPI-style serial link. The link has an active-low load strobe, an active-low clock enable, a serial clock, a serial input and a serial output.

While the load strobe is low, the register copies the filtered states. Once the strobe is high, the register is cut off from the inputs and holds what it captured. Each rising serial-clock edge that arrives with the enable low moves the contents one place toward the output. Channel 7 is presented first and channel 0 last. After those eight bits, whatever came in on the serial input follows. Several copies chain output-to-input, and the host interface stays the same.

The serial clock, strobe, enable and serial input are sampled by the system clock, so the host's serial clock must stay high and low for at least three system clocks each. A parameter gives the system clock frequency in hertz, and the debounce counts are derived from it.

Top module: `octal_debounce_serializer`

## Requirements
- R1: While reset is asserted, the serial output is low. After reset, every filtered state and every shift-register bit is zero.
- R2: While the load strobe is low, the shift register takes the filtered channel states, with channel i in register bit i. The serial output shows register bit 7, so after a load it presents channel 7.
- R3: With the load strobe high, later changes on the raw inputs do not change the register contents read out.
- R4: Rising serial-clock edges that arrive while the clock enable is high do not move the register.
- R5: Each rising serial-clock edge with the enable low and the strobe high shifts the register one place toward the output, and the serial input bit enters at bit 0. The first serial-input bit therefore reaches the output after eight such edges.
- R6: When one block's serial output feeds a second block's serial input, sixteen enabled edges read the second block's eight channels first and then the first block's eight channels.
- R7: Select value 2'b11 (both pins high, the idle default) turns filtering off. The filtered state then follows the synchronized input one system clock later.
- R8: Select value 2'b10 (pin 0 low) applies a dwell of CLK_HZ/1000 system clocks. A filtered state changes only after its synchronized input has held the opposite level for that many consecutive clocks.
- R9: Select values 2'b00 and 2'b01 apply a dwell of 3*CLK_HZ/1000 system clocks, with the same rule.
- R10: An input pulse shorter than the selected dwell leaves the filtered state unchanged, and the channel's count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock driving the synchronizers and debounce counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | CHANNELS | Raw field input levels, channel 0 at bit 0 |
| dbsel | input | 2 | Debounce select straps, held high when unconnected |
| ld_n | input | 1 | Active-low parallel load strobe |
| ce_n | input | 1 | Active-low serial clock enable |
| sclk | input | 1 | Serial shift clock; it acts on its rising edge |
| sin | input | 1 | Serial cascade input |
| sout | output | 1 | Serial output, showing register bit 7 |

## Verification
A raw input change reaches the synchronized copy two system clocks later. The filtered state follows one clock after that with filtering off, or a full dwell after that otherwise. The load strobe and serial clock each pass through the same two-flop pipeline, plus one clock for the register update. The bench drives everything on falling edges and holds each strobe or clock level for four system clocks. It reads the serial output only after those four clocks have passed, which leaves at least one clock of margin. The debounce checks load either right after an input change or a fixed 14 clocks later. With 8-clock and 24-clock dwells, the capture then falls clearly before or after the filtered change, so the expected old or new value is exact.

// File: rtl/odsr_pkg.sv
package odsr_pkg;

  typedef enum logic [1:0] {
    DWELL_LONG_A = 2'b00,
    DWELL_LONG_B = 2'b01,
    DWELL_SHORT  = 2'b10,
    DWELL_OFF    = 2'b11
  } dwell_sel_e;

  // Dwell length in system clocks for a select code; ticks = clocks per ms.
  function automatic int unsigned dwell_cycles(input logic [1:0] sel,
                                               input int unsigned ticks);
    case (dwell_sel_e'(sel))
      DWELL_OFF:   return 0;
      DWELL_SHORT: return ticks;
      default:     return 3 * ticks;
    endcase
  endfunction

endpackage

// File: rtl/odsr_sync.sv
module odsr_sync #(
  parameter int            W       = 4,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/odsr_debounce.sv
module odsr_debounce #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          bypass,
  input  logic [CW-1:0] dwell,
  output logic          q
);
  logic [CW-1:0] cnt;
  logic          differs, expired;

  assign differs = (din != q);
  assign expired = (cnt >= dwell - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (bypass) begin
      q   <= din;
      cnt <= '0;
    end else if (!differs) begin
      cnt <= '0;
    end else if (expired) begin
      q   <= din;
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/odsr_shift.sv
module odsr_shift #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         ser_in,
  input  logic [N-1:0] par_in,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= par_in;
    else if (step) q <= {q[N-2:0], ser_in};
  end
endmodule

// File: rtl/octal_debounce_serializer.sv
module octal_debounce_serializer #(
  parameter int CHANNELS    = 8,
  parameter int CLK_HZ      = 50_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] raw_in,
  input  logic [1:0]          dbsel,
  input  logic                ld_n,
  input  logic                ce_n,
  input  logic                sclk,
  input  logic                sin,
  output logic                sout
);
  localparam int TICKS     = CLK_HZ / 1000;
  localparam int MAX_DWELL = 3 * TICKS;
  localparam int CW        = $clog2(MAX_DWELL + 1);
  localparam int SW        = CHANNELS + 4;
  localparam logic [SW-1:0] SYNC_RST = {{CHANNELS{1'b0}}, 4'b1100};

  logic [SW-1:0]       sync_out;
  logic [CHANNELS-1:0] sync_vec;
  logic                ld_q, ce_q, sclk_q, sin_q, sclk_prev;

  odsr_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({raw_in, ld_n, ce_n, sclk, sin}),
    .q   (sync_out)
  );

  assign {sync_vec, ld_q, ce_q, sclk_q, sin_q} = sync_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_q;
  end

  // Named events for the checker.
  logic ld_active, shift_evt;
  assign ld_active = ~ld_q;
  assign shift_evt = sclk_q & ~sclk_prev & ~ce_q;

  logic [CW-1:0] dwell;
  logic          bypass;
  assign dwell  = CW'(odsr_pkg::dwell_cycles(dbsel, TICKS));
  assign bypass = (dwell == '0);

  logic [CHANNELS-1:0] filt_vec;
  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    odsr_debounce #(.CW(CW)) u_deb (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (sync_vec[g]),
      .bypass (bypass),
      .dwell  (dwell),
      .q      (filt_vec[g])
    );
  end

  logic [CHANNELS-1:0] shreg_q;
  odsr_shift #(.N(CHANNELS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (ld_active),
    .step   (shift_evt),
    .ser_in (sin_q),
    .par_in (filt_vec),
    .q      (shreg_q)
  );

  assign sout = shreg_q[CHANNELS-1];
endmodule

// File: rtl/odsr_checker.sv
module odsr_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   dbsel,
  input logic         ld_active,
  input logic         shift_evt,
  input logic         sin_q,
  input logic [N-1:0] sync_vec,
  input logic [N-1:0] filt_vec,
  input logic [N-1:0] shreg_q
);
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_active |=> (shreg_q == $past(filt_vec))); // R2

  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_active && !shift_evt) |=> $stable(shreg_q)); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_active && shift_evt) |=>
      (shreg_q == {$past(shreg_q[N-2:0]), $past(sin_q)})); // R5

  AST_BYPASS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dbsel == 2'b11) |=> (filt_vec == $past(sync_vec))); // R7

  AST_FILTER_TOWARD_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (dbsel != 2'b11) |=>
      (((filt_vec ^ $past(filt_vec)) & (filt_vec ^ $past(sync_vec))) == '0)); // R8
endmodule

bind octal_debounce_serializer odsr_checker #(.N(CHANNELS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dbsel     (dbsel),
  .ld_active (ld_active),
  .shift_evt (shift_evt),
  .sin_q     (sin_q),
  .sync_vec  (sync_vec),
  .filt_vec  (filt_vec),
  .shreg_q   (shreg_q)
);

// File: tb/octal_debounce_serializer_test.sv
module octal_debounce_serializer_test;
  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 8000;      // 8 clocks per ms
  localparam int T1         = HZ / 1000; // 1 ms dwell
  localparam int T3         = 3 * T1;    // 3 ms dwell

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] raw_h = '0, raw_t = '0;
  logic [1:0] dbsel = 2'b11;
  logic       ld_n = 1'b1, ce_n = 1'b1, sclk = 1'b0, sin_h = 1'b0;
  logic       sout_h, sout_t;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  octal_debounce_serializer #(.CHANNELS(8), .CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_h), .dbsel(dbsel), .ld_n(ld_n),
    .ce_n(ce_n), .sclk(sclk), .sin(sin_h), .sout(sout_h));

  octal_debounce_serializer #(.CHANNELS(8), .CLK_HZ(HZ)) uut_tail (
    .clk(clk), .rst_n(rst_n), .raw_in(raw_t), .dbsel(dbsel), .ld_n(ld_n),
    .ce_n(ce_n), .sclk(sclk), .sin(sout_h), .sout(sout_t));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load();
    ld_n = 1'b0; wait_clk(4);
    ld_n = 1'b1; wait_clk(4);
  endtask

  // Reads n bits (first one at bit n-1), driving stream[n-1-k] on sin at step k.
  task automatic shift_bits(input int n, input logic [31:0] stream,
                            output logic [31:0] gh, output logic [31:0] gt);
    gh = '0; gt = '0;
    ce_n = 1'b0;
    for (int k = 0; k < n; k++) begin
      gh[n-1-k] = sout_h;
      gt[n-1-k] = sout_t;
      sin_h = stream[n-1-k];
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    ce_n = 1'b1;
    sin_h = 1'b0;
  endtask

  task automatic read8(output logic [7:0] h, output logic [7:0] t);
    logic [31:0] gh, gt;
    do_load();
    shift_bits(8, 32'h0, gh, gt);
    h = gh[7:0]; t = gt[7:0];
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0]  h, t;
    logic [31:0] gh, gt;
    logic [1:0]  sels [3];
    int          dw [3];
    sels[0] = 2'b10; sels[1] = 2'b00; sels[2] = 2'b01;
    dw[0] = T1; dw[1] = T3; dw[2] = T3;

    // R1: reset state
    wait_clk(3);
    check("R1 sout head in reset", {31'b0, sout_h}, 32'h0);
    check("R1 sout tail in reset", {31'b0, sout_t}, 32'h0);
    rst_n = 1'b1;
    wait_clk(4);
    read8(h, t);
    check("R1 register zero after reset", {24'b0, h}, 32'h0);

    // R2 R7: exhaustive sweep of channel patterns, no filtering
    dbsel = 2'b11;
    for (int v = 0; v < 256; v++) begin
      raw_h = 8'(v);
      raw_t = ~8'(v);
      wait_clk(6);
      read8(h, t);
      check("R2 R7 head pattern", {24'b0, h}, 32'(v));
      check("R2 R7 tail pattern", {24'b0, t}, {24'b0, ~8'(v)});
    end

    // R3: input changes after load do not reach the register
    raw_h = 8'hA5; wait_clk(6);
    do_load();
    raw_h = 8'h5A; wait_clk(10);
    shift_bits(8, 32'h0, gh, gt);
    check("R3 held after load", gh, 32'hA5);

    // R4: clock edges with enable high are ignored
    raw_h = 8'h96; wait_clk(6);
    do_load();
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    check("R4 sout unchanged after disabled clocks", {31'b0, sout_h}, 32'h1);
    shift_bits(8, 32'h0, gh, gt);
    check("R4 full byte after disabled clocks", gh, 32'h96);

    // R5: serial input follows the eight captured bits
    raw_h = 8'h3E; wait_clk(6);
    do_load();
    shift_bits(16, 32'h0000_C7_00, gh, gt);
    check("R5 byte then serial input", gh, 32'h3EC7);

    // R6: two chained blocks
    raw_h = 8'h81; raw_t = 8'h6D; wait_clk(6);
    do_load();
    shift_bits(16, 32'h0, gh, gt);
    check("R6 tail then head", gt, 32'h6D81);

    // R8 R9 R10: dwell settings
    for (int s = 0; s < 3; s++) begin
      dbsel = sels[s];
      raw_h = 8'h3C;
      wait_clk(dw[s] + 20);
      read8(h, t);
      check("R8 R9 settled baseline", {24'b0, h}, 32'h3C);

      raw_h = 8'hC3;
      read8(h, t);
      check("R8 R9 no change right after input edge", {24'b0, h}, 32'h3C);
      wait_clk(dw[s] + 20);
      read8(h, t);
      check("R8 R9 change after dwell", {24'b0, h}, 32'hC3);

      raw_h = 8'h3C;
      wait_clk(14);
      read8(h, t);
      if (dw[s] == T1)
        check("R8 short dwell done at 14 clocks", {24'b0, h}, 32'h3C);
      else
        check("R9 long dwell pending at 14 clocks", {24'b0, h}, 32'hC3);
      wait_clk(dw[s] + 20);

      raw_h = 8'hC3;
      wait_clk(dw[s] - 1);
      raw_h = 8'h3C;
      wait_clk(dw[s] + 20);
      read8(h, t);
      check("R10 short pulse rejected", {24'b0, h}, 32'h3C);

      raw_h = 8'hC3; wait_clk(dw[s] - 2);
      raw_h = 8'h3C; wait_clk(2);
      raw_h = 8'hC3; wait_clk(dw[s] - 2);
      raw_h = 8'h3C; wait_clk(dw[s] + 20);
      read8(h, t);
      check("R10 glitch restarts count", {24'b0, h}, 32'h3C);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule